// File: doc/BRIEF.md
# Serial NOR Flash Command Engine

This block is the command layer of a serial NOR flash slave. The SPI link is already deserialized: each transfer delivers one byte with `rxValid` while the active-low select `csN` is held low, and the engine registers one response byte per transfer on `txByte`. The engine decodes the first byte of a frame as an opcode. It then gathers address or data bytes and serves reads from, or programs into, a small on-chip array whose size is a parameter. It also handles three erase granularities, the write-enable latch, status, flag and identification reads, a switch between 3-byte and 4-byte addressing, an extended address register, and a software reset that needs an arming command first.

A frame ends when `csN` rises. Any command still in progress is dropped at that point, except the variable-length status write, which is processed at deselect. Programming clears bits only (AND with the stored byte), unless the `EEPROM` parameter is set, in which case the byte replaces the stored value. In 3-byte mode the extended address register is placed above address bit 23, and the combined address is then reduced modulo the array size.

Top module: `nor_flash_engine`

## Requirements
- R1: After `rstN` low, `txByte` is 0x00, every array byte reads 0xFF, the status byte reads 0x00, and the flag byte (opcode 0x70) reads 0x80. This applies at power-up and after a later reset.
- R2: The response is 0x00 for every opcode byte, address byte, collected data byte and program byte. An unknown opcode is ignored, and the next byte of the same frame is decoded as an opcode.
- R3: Opcode 0x03 takes 3 address bytes, most significant first. Each following byte returns the array byte at the current address, and the address then increments modulo `MEM_BYTES`.
- R4: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Status (0x05) returns the latch in bit 1. While the latch is clear, program and erase leave the array unchanged.
- R5: Opcode 0x02 takes an address and then programs one byte per transfer at incrementing, wrapping addresses. Each program byte is ANDed into the stored byte, or overwrites it when `EEPROM` is set.
- R6: Erase fills a region aligned to its size with 0xFF. Opcode 0x20 erases `SUB_BYTES`. Opcode 0xD8 erases `SECT_BYTES`. Opcode 0xDC does the same as 0xD8 but always takes 4 address bytes. Opcode 0xC7 erases the whole array.
- R7: Opcode 0xB7 enters 4-byte mode and 0xE9 leaves it. Flag bit 0 shows the mode and flag bit 7 is always 1 (ready). In 4-byte mode, address commands take 4 address bytes.
- R8: Opcode 0xC8 returns the extended address register. Opcode 0xC5 loads that register from one data byte, but only while write-enable is set. In 3-byte mode the register supplies address bits 31..24 before reduction modulo the array size.
- R9: Reset (0x99) acts only when the opcode decoded just before it was 0x66; any other opcode disarms it. An effective reset clears write-enable, 4-byte mode and the extended address register, and leaves the array untouched.
- R10: Raising `csN` aborts any command and returns the engine to opcode decode. Bytes offered while `csN` is high are ignored. Opcode 0x01 (accepted only with write-enable set) collects any number of bytes, and at deselect it clears write-enable.
- R11: A response command returns exactly its prepared bytes and then decodes the next byte as an opcode. Status and flag return 1 byte, 0xC8 returns 1 byte, and 0x9F returns the first `ID_LEN` bytes of `ID_BYTES`, most significant byte first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| csN | input | 1 | Active-low chip select; high ends the frame |
| rxValid | input | 1 | One received byte is present this cycle |
| rxByte | input | 8 | Received byte |
| txByte | output | 8 | Response byte for the last accepted transfer |

## Verification
The hardest states to reach are those that depend on command history rather than on a single command. These include a reset disarmed by an opcode between the arming and the reset, a second write to the extended register that the cleared latch blocks, and a status write that only takes effect when select rises. The stimulus reaches them with long frame sequences that set the latch, modes and registers in one order and then read them back through the status, flag and 0xC8 responses. Address wrap is exercised by programming and reading across the last array byte. Erase alignment is checked by erasing with an unaligned address and reading bytes on both sides of the region boundary.

// File: rtl/nor_pkg.sv
package nor_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_COLLECT, ST_VARLEN, ST_RESPOND, ST_READ, ST_PROG
  } eng_state_e;

  typedef enum logic [1:0] {ER_NONE, ER_SUB, ER_SECT, ER_ALL} erase_e;

  typedef struct packed {
    logic   wrEn;
    erase_e erase;
  } strobe_t;

  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_WRSR   = 8'h01;
  localparam logic [7:0] OP_FLAG   = 8'h70;
  localparam logic [7:0] OP_RDID   = 8'h9F;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_SUB    = 8'h20;
  localparam logic [7:0] OP_SECT   = 8'hD8;
  localparam logic [7:0] OP_SECT4  = 8'hDC;
  localparam logic [7:0] OP_CHIP   = 8'hC7;
  localparam logic [7:0] OP_EN4    = 8'hB7;
  localparam logic [7:0] OP_EX4    = 8'hE9;
  localparam logic [7:0] OP_RDEAR  = 8'hC8;
  localparam logic [7:0] OP_WREAR  = 8'hC5;
  localparam logic [7:0] OP_RSTEN  = 8'h66;
  localparam logic [7:0] OP_RST    = 8'h99;

endpackage

// File: rtl/nor_datapath.sv
module nor_datapath
  import nor_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int SUB_BYTES  = 64,
  parameter int SECT_BYTES = 256,
  parameter bit EEPROM     = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] SUB_KEEP  = ~ADDR_W'(SUB_BYTES - 1);
  localparam logic [ADDR_W-1:0] SECT_KEEP = ~ADDR_W'(SECT_BYTES - 1);

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] keep;

  assign rdData = mem[addr];

  always_comb begin
    case (strb.erase)
      ER_SUB:  keep = SUB_KEEP;
      ER_SECT: keep = SECT_KEEP;
      default: keep = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (strb.erase != ER_NONE) begin
      for (int i = 0; i < DEPTH; i++)
        if ((ADDR_W'(i) & keep) == (addr & keep)) mem[i] <= 8'hFF;
    end else if (strb.wrEn) begin
      mem[addr] <= EEPROM ? wrData : (mem[addr] & wrData);
    end
  end

  // R5
  clear_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!EEPROM && strb.wrEn) |=> ((mem[$past(addr)] & ~$past(rdData)) == 8'h00));

  // R6
  chip_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.erase == ER_ALL) |=> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF));

endmodule

// File: rtl/nor_ctrl.sv
module nor_ctrl
  import nor_pkg::*;
#(
  parameter int          ADDR_W   = 10,
  parameter int          ID_LEN   = 5,
  parameter logic [47:0] ID_BYTES = 48'hC3_71_15_2E_90_00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic [7:0]        rdData,
  output logic [7:0]        txByte,
  output strobe_t           strb,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        wrData
);

  localparam logic [63:0] ID_PAD = {ID_BYTES, 16'h0000};

  eng_state_e        state;
  logic [7:0]        cmd;
  logic [2:0]        need, cnt, cntNext;
  logic [23:0]       acc;
  logic [31:0]       fullAcc;
  logic [ADDR_W-1:0] curAddr, collAddr;
  logic              wel, mode4, resEn, take, lastColl, fourB;
  logic [7:0]        ear;
  logic [7:0]        respBuf [8];
  logic [2:0]        respLen, respPos;

  assign take     = rxValid && !csN;
  assign fullAcc  = {acc, rxByte};
  assign fourB    = mode4 || (cmd == OP_SECT4);
  assign collAddr = ADDR_W'(fourB ? fullAcc : {ear, fullAcc[23:0]});
  assign cntNext  = cnt + 3'd1;
  assign lastColl = (cntNext == need);
  assign memAddr  = (state == ST_COLLECT) ? collAddr : curAddr;
  assign wrData   = rxByte;

  always_comb begin
    strb.wrEn  = take && (state == ST_PROG) && wel;
    strb.erase = ER_NONE;
    if (take && wel) begin
      if (state == ST_IDLE && rxByte == OP_CHIP) strb.erase = ER_ALL;
      else if (state == ST_COLLECT && lastColl) begin
        if (cmd == OP_SUB) strb.erase = ER_SUB;
        else if (cmd == OP_SECT || cmd == OP_SECT4) strb.erase = ER_SECT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cmd     <= 8'h00;
      need    <= 3'd0;
      cnt     <= 3'd0;
      acc     <= '0;
      curAddr <= '0;
      wel     <= 1'b0;
      mode4   <= 1'b0;
      resEn   <= 1'b0;
      ear     <= 8'h00;
      respLen <= 3'd0;
      respPos <= 3'd0;
      txByte  <= 8'h00;
      for (int i = 0; i < 8; i++) respBuf[i] <= 8'h00;
    end else if (csN) begin
      if (state == ST_VARLEN) wel <= 1'b0;
      state <= ST_IDLE;
    end else if (rxValid) begin
      txByte <= 8'h00;
      case (state)
        ST_IDLE: begin
          cmd     <= rxByte;
          cnt     <= 3'd0;
          acc     <= '0;
          respPos <= 3'd0;
          respLen <= 3'd1;
          resEn   <= (rxByte == OP_RSTEN);
          case (rxByte)
            OP_WREN:  wel <= 1'b1;
            OP_WRDI:  wel <= 1'b0;
            OP_EN4:   mode4 <= 1'b1;
            OP_EX4:   mode4 <= 1'b0;
            OP_RDSR:  begin respBuf[0] <= {6'b0, wel, 1'b0};   state <= ST_RESPOND; end
            OP_FLAG:  begin respBuf[0] <= {1'b1, 6'b0, mode4}; state <= ST_RESPOND; end
            OP_RDEAR: begin respBuf[0] <= ear;                 state <= ST_RESPOND; end
            OP_RDID: begin
              for (int i = 0; i < 8; i++) respBuf[i] <= ID_PAD[8*(7-i) +: 8];
              respLen <= 3'(ID_LEN);
              state   <= ST_RESPOND;
            end
            OP_READ, OP_PROG, OP_SUB, OP_SECT, OP_SECT4: begin
              need  <= (mode4 || rxByte == OP_SECT4) ? 3'd4 : 3'd3;
              state <= ST_COLLECT;
            end
            OP_WREAR: if (wel) begin need <= 3'd1; state <= ST_COLLECT; end
            OP_WRSR:  if (wel) state <= ST_VARLEN;
            OP_RST: if (resEn) begin
              wel   <= 1'b0;
              mode4 <= 1'b0;
              ear   <= 8'h00;
            end
            default: ;
          endcase
        end
        ST_COLLECT: begin
          acc <= fullAcc[23:0];
          cnt <= cntNext;
          if (lastColl) begin
            state <= ST_IDLE;
            if (cmd == OP_READ) begin
              curAddr <= collAddr;
              state   <= ST_READ;
            end else if (cmd == OP_PROG) begin
              curAddr <= collAddr;
              state   <= ST_PROG;
            end else if (cmd == OP_WREAR) begin
              ear <= rxByte;
            end
          end
        end
        ST_RESPOND: begin
          txByte  <= respBuf[respPos];
          respPos <= respPos + 3'd1;
          if (respPos + 3'd1 == respLen) state <= ST_IDLE;
        end
        ST_READ: begin
          txByte  <= rdData;
          curAddr <= curAddr + 1'b1;
        end
        ST_PROG: curAddr <= curAddr + 1'b1;
        default: ;
      endcase
    end
  end

  // R2
  quiet_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (take && (state == ST_IDLE || state == ST_COLLECT || state == ST_PROG))
      |=> (txByte == 8'h00));

  // R10
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (state == ST_IDLE));

  // R3
  read_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (take && state == ST_READ && curAddr == {ADDR_W{1'b1}}) |=> (curAddr == '0));

  // R9
  rsten_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (take && state == ST_IDLE && rxByte != OP_RSTEN) |=> !resEn);

endmodule

// File: rtl/nor_flash_engine.sv
module nor_flash_engine
  import nor_pkg::*;
#(
  parameter int          MEM_BYTES  = 1024,
  parameter int          SUB_BYTES  = 64,
  parameter int          SECT_BYTES = 256,
  parameter bit          EEPROM     = 1'b0,
  parameter int          ID_LEN     = 5,
  parameter logic [47:0] ID_BYTES   = 48'hC3_71_15_2E_90_00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  output logic [7:0] txByte
);

  localparam int ADDR_W = $clog2(MEM_BYTES);

  strobe_t           strb;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0]        wrData, rdData;

  nor_ctrl #(.ADDR_W(ADDR_W), .ID_LEN(ID_LEN), .ID_BYTES(ID_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rxValid(rxValid), .rxByte(rxByte),
    .rdData(rdData), .txByte(txByte), .strb(strb), .memAddr(memAddr),
    .wrData(wrData)
  );

  nor_datapath #(.ADDR_W(ADDR_W), .SUB_BYTES(SUB_BYTES),
                 .SECT_BYTES(SECT_BYTES), .EEPROM(EEPROM)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(memAddr),
    .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: tb/nor_flash_engine_tb.sv
module nor_flash_engine_tb;

  logic       clk = 1'b0;
  logic       rstN, csN, rxValid;
  logic [7:0] rxByte;
  logic [7:0] txByte;
  int         nChk = 0;
  int         nBad = 0;

  always #10 clk = ~clk;

  nor_flash_engine u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rxValid(rxValid),
    .rxByte(rxByte), .txByte(txByte)
  );

  // Row format 24'hR_S_BB_EE: R = requirement to check (0 = none),
  // S = 1 starts a new frame, BB = byte sent, EE = expected response.
  localparam int NV = 197;
  localparam logic [23:0] VEC [NV] = '{
    // R1 reset status and flag
    24'h0_1_05_00, 24'h1_0_00_00, 24'h0_1_70_00, 24'h1_0_00_80,
    // R4 latch set
    24'h0_1_06_00, 24'h0_1_05_00, 24'h4_0_00_02,
    // R3 blank read, R2 quiet program phases
    24'h0_1_03_00, 24'h0_0_00_00, 24'h0_0_01_00, 24'h0_0_00_00, 24'h3_0_00_FF,
    24'h2_1_02_00, 24'h0_0_00_00, 24'h0_0_01_00, 24'h0_0_00_00, 24'h2_0_A5_00, 24'h0_0_3C_00,
    24'h0_1_02_00, 24'h0_0_00_00, 24'h0_0_01_00, 24'h0_0_40_00, 24'h0_0_44_00,
    24'h0_1_03_00, 24'h0_0_00_00, 24'h0_0_01_00, 24'h0_0_00_00, 24'h3_0_00_A5, 24'h3_0_00_3C, 24'h3_0_00_FF,
    // R5 AND programming
    24'h0_1_02_00, 24'h0_0_00_00, 24'h0_0_01_00, 24'h0_0_00_00, 24'h0_0_5A_00,
    24'h0_1_03_00, 24'h0_0_00_00, 24'h0_0_01_00, 24'h0_0_00_00, 24'h5_0_00_00, 24'h5_0_00_3C,
    // R5 R3 wrap across the last byte
    24'h0_1_02_00, 24'h0_0_00_00, 24'h0_0_03_00, 24'h0_0_FF_00, 24'h0_0_11_00, 24'h0_0_22_00,
    24'h0_1_03_00, 24'h0_0_00_00, 24'h0_0_03_00, 24'h0_0_FF_00, 24'h5_0_00_11, 24'h3_0_00_22,
    // R4 latch clear blocks program and erase
    24'h0_1_04_00,
    24'h0_1_02_00, 24'h0_0_00_00, 24'h0_0_02_00, 24'h0_0_00_00, 24'h0_0_77_00,
    24'h0_1_03_00, 24'h0_0_00_00, 24'h0_0_02_00, 24'h0_0_00_00, 24'h4_0_00_FF,
    24'h0_1_20_00, 24'h0_0_00_00, 24'h0_0_01_00, 24'h0_0_00_00,
    24'h0_1_03_00, 24'h0_0_00_00, 24'h0_0_01_00, 24'h0_0_00_00, 24'h4_0_00_00,
    // R6 aligned subsector and sector erase
    24'h0_1_06_00,
    24'h0_1_20_00, 24'h0_0_00_00, 24'h0_0_01_00, 24'h0_0_3F_00,
    24'h0_1_03_00, 24'h0_0_00_00, 24'h0_0_01_00, 24'h0_0_00_00, 24'h6_0_00_FF,
    24'h0_1_03_00, 24'h0_0_00_00, 24'h0_0_01_00, 24'h0_0_40_00, 24'h6_0_00_44,
    24'h0_1_D8_00, 24'h0_0_00_00, 24'h0_0_01_00, 24'h0_0_C0_00,
    24'h0_1_03_00, 24'h0_0_00_00, 24'h0_0_01_00, 24'h0_0_40_00, 24'h6_0_00_FF,
    24'h0_1_03_00, 24'h0_0_00_00, 24'h0_0_00_00, 24'h0_0_00_00, 24'h6_0_00_22,
    // R7 4-byte mode
    24'h0_1_B7_00, 24'h0_1_70_00, 24'h7_0_00_81,
    24'h0_1_03_00, 24'h0_0_00_00, 24'h0_0_00_00, 24'h0_0_03_00, 24'h0_0_FF_00, 24'h7_0_00_11,
    24'h0_1_E9_00, 24'h0_1_70_00, 24'h7_0_00_80,
    // R6 4-byte sector erase in 3-byte mode
    24'h0_1_02_00, 24'h0_0_00_00, 24'h0_0_02_00, 24'h0_0_00_00, 24'h0_0_66_00,
    24'h0_1_03_00, 24'h0_0_00_00, 24'h0_0_02_00, 24'h0_0_00_00, 24'h5_0_00_66,
    24'h0_1_DC_00, 24'h0_0_00_00, 24'h0_0_00_00, 24'h0_0_02_00, 24'h0_0_10_00,
    24'h0_1_03_00, 24'h0_0_00_00, 24'h0_0_02_00, 24'h0_0_00_00, 24'h6_0_00_FF,
    // R8 extended address register
    24'h0_1_C5_00, 24'h0_0_07_00, 24'h0_1_C8_00, 24'h8_0_00_07,
    24'h0_1_03_00, 24'h0_0_00_00, 24'h0_0_03_00, 24'h0_0_FF_00, 24'h8_0_00_11,
    24'h0_1_04_00, 24'h0_1_C5_00, 24'h0_0_09_00, 24'h0_1_C8_00, 24'h8_0_00_07,
    // R9 two-step reset
    24'h0_1_06_00, 24'h0_1_B7_00, 24'h0_1_66_00, 24'h0_1_05_00, 24'h9_0_00_02,
    24'h0_1_99_00, 24'h0_1_70_00, 24'h9_0_00_81,
    24'h0_1_66_00, 24'h0_1_99_00, 24'h0_1_70_00, 24'h9_0_00_80,
    24'h0_1_05_00, 24'h9_0_00_00, 24'h0_1_C8_00, 24'h9_0_00_00,
    // R11 response end and identification
    24'h0_1_05_00, 24'hB_0_00_00, 24'hB_0_06_00, 24'h0_1_05_00, 24'hB_0_00_02,
    24'h0_1_9F_00, 24'hB_0_00_C3, 24'hB_0_00_71, 24'hB_0_00_15, 24'hB_0_00_2E,
    24'hB_0_00_90, 24'hB_0_00_00,
    // R10 deselect aborts; variable-length status write
    24'h0_1_03_00, 24'h0_0_00_00, 24'h0_0_00_00, 24'h0_1_70_00, 24'hA_0_00_80,
    24'h0_1_01_00, 24'h0_0_AA_00, 24'h0_0_BB_00, 24'h0_0_CC_00,
    24'h0_1_05_00, 24'hA_0_00_00,
    // R6 chip erase, R2 unknown opcode
    24'h0_1_06_00, 24'h0_1_C7_00,
    24'h0_1_03_00, 24'h0_0_00_00, 24'h0_0_03_00, 24'h0_0_FF_00, 24'h6_0_00_FF,
    24'h0_1_AB_00, 24'h2_0_70_00, 24'h2_0_00_80
  };

  task automatic check(input int req, input int row, input logic [7:0] act,
                       input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL R%0d step %0d actual=%02h expected=%02h", req, row, act, exp);
    end
  endtask

  task automatic xfer(input logic st, input logic [7:0] b, output logic [7:0] r);
    if (st) begin
      csN = 1'b1; rxValid = 1'b0;
      @(negedge clk);
    end
    csN = 1'b0; rxValid = 1'b1; rxByte = b;
    @(negedge clk);
    rxValid = 1'b0;
    r = txByte;
  endtask

  task automatic doReset();
    rstN = 1'b0; csN = 1'b1; rxValid = 1'b0; rxByte = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [7:0] got;
    doReset();
    check(1, -1, txByte, 8'h00);                     // R1 reset response

    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i][16], VEC[i][15:8], got);
      if (VEC[i][23:20] != 4'd0) check(int'(VEC[i][23:20]), i, got, VEC[i][7:0]);
    end

    // R10: a byte offered while deselected has no effect
    xfer(1'b1, 8'h04, got);
    csN = 1'b1; rxValid = 1'b1; rxByte = 8'h06;
    @(negedge clk);
    rxValid = 1'b0;
    xfer(1'b1, 8'h05, got);
    xfer(1'b0, 8'h00, got);
    check(10, 1000, got, 8'h00);

    // R5 then R1: program a byte, reset mid-run, everything returns to power-up
    xfer(1'b1, 8'h06, got);
    xfer(1'b1, 8'hB7, got);
    xfer(1'b1, 8'h02, got); xfer(1'b0, 8'h00, got); xfer(1'b0, 8'h00, got);
    xfer(1'b0, 8'h00, got); xfer(1'b0, 8'h10, got); xfer(1'b0, 8'h12, got);
    xfer(1'b1, 8'h03, got); xfer(1'b0, 8'h00, got); xfer(1'b0, 8'h00, got);
    xfer(1'b0, 8'h00, got); xfer(1'b0, 8'h10, got); xfer(1'b0, 8'h00, got);
    check(5, 1001, got, 8'h12);
    doReset();
    check(1, 1002, txByte, 8'h00);
    xfer(1'b1, 8'h70, got); xfer(1'b0, 8'h00, got);
    check(1, 1003, got, 8'h80);
    xfer(1'b1, 8'h03, got); xfer(1'b0, 8'h00, got); xfer(1'b0, 8'h00, got);
    xfer(1'b0, 8'h10, got); xfer(1'b0, 8'h00, got);
    check(1, 1004, got, 8'hFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule